// File: doc/BRIEF.md
# GPE and Slot Hotplug Controller

This block holds a 16-bit general-purpose event status/enable pair and the notification state for slot hotplug, all reached over a simple single-cycle register bus. Hardware reports an insertion or removal with a one-cycle `hp_event` strobe, a direction bit and a 5-bit slot number. The block records the slot in one of two 32-bit slot bitmaps, raises event status bit 1 and, when enable bit 1 is set, emits a one-cycle high pulse on `sci` to signal software. Software acknowledges the event by clearing status bits, and requests ejection by writing a slot mask to the eject register. The block turns that mask into a one-cycle strobe that carries the index of the lowest set bit.

Register map (byte offsets on `bus_addr`). The event registers are byte wide and use `bus_wdata[7:0]`:
- 0x00 is status bits 7..0 and 0x01 is status bits 15..8. A write clears the bits written as one.
- 0x02 is enable bits 7..0 and 0x03 is enable bits 15..8. A write replaces the byte.

The slot and eject registers are 32 bits wide:
- 0x08 is the inserted-slot bitmap, read/write.
- 0x0C is the removed-slot bitmap, read/write.
- 0x10 is the eject register. It is write-only and reads as zero.

Every other offset reads as zero, and a write to it has no effect. Writes take effect at the rising clock edge when `bus_wr` is high. Reads are combinational from `bus_addr`.

The `sci` pulse generator is a three-state machine:
- IDLE: `sci` is low. The transition IDLE→HIGH is taken on an enabled event.
- HIGH: `sci` is high for one cycle. The transition HIGH→GAP is always taken. An enabled event that arrives in HIGH is remembered as pending.
- GAP: `sci` is low for one cycle. The transition GAP→HIGH is taken when an event is pending or an enabled event arrives. Otherwise GAP→IDLE is taken.

Top module: `gpe_hotplug_ctrl`

## Requirements
- R1: After reset every register reads zero, `sci` is low and `ej_valid` is low. A read of offset 0x00/0x01 returns status bits 7..0/15..8, and a read of 0x02/0x03 returns enable bits 7..0/15..8, in `bus_rdata[7:0]` with the upper bits zero.
- R2: A write to a status byte clears exactly the bits of that byte whose `bus_wdata` bit is one. The other status byte is unchanged.
- R3: A write to an enable byte replaces that byte with `bus_wdata[7:0]`. The other byte is unchanged. Enable changes only through such writes.
- R4: The inserted bitmap (0x08) and the removed bitmap (0x0C) are 32-bit registers that are written and read back in full.
- R5: On `hp_event`, both bitmaps are cleared. Then bit `hp_slot` is set in the inserted bitmap if `hp_insert`=1, or in the removed bitmap if `hp_insert`=0.
- R6: Every `hp_event` sets status bit 1.
- R7: If enable bit 1 is set when `hp_event` is sampled, `sci` is high for exactly the following cycle and then low. With enable bit 1 clear, `sci` stays low.
- R8: A write of a nonzero value to 0x10 gives `ej_valid` high for exactly the following cycle, with `ej_slot` equal to the index of the lowest set bit of the written value. A read of 0x10 returns zero.
- R9: A write of zero to 0x10 produces no `ej_valid` pulse.
- R10: When `hp_event` and a software write to a bitmap or to status byte 0 fall in the same cycle, the hotplug update wins. The bitmaps hold only the event's slot bit, and status bit 1 ends up set.
- R11: An enabled event that arrives while `sci` is high produces a second high cycle after exactly one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| hp_event | input | 1 | One-cycle hotplug event strobe |
| hp_insert | input | 1 | 1 = insertion, 0 = removal |
| hp_slot | input | 5 | Slot number of the event |
| ej_valid | output | 1 | One-cycle eject request strobe |
| ej_slot | output | 5 | Slot to eject, valid with `ej_valid` |
| sci | output | 1 | Software interrupt pulse |

## Verification
The hardest situations to reach from the ports are the collisions. One is a hotplug event in the very cycle software writes the same bitmap or clears status. The other is a second enabled event that lands while `sci` is already high. The bench drives `hp_event` and `bus_wr` in the same clock window for the first case. For the second case it issues the next event in the cycle immediately after the first one. It then samples the register readback and `sci` cycle by cycle, so the winner of the collision and the single low gap between pulses are both observed.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;
    typedef enum logic [1:0] {
        SCI_IDLE = 2'd0,
        SCI_HIGH = 2'd1,
        SCI_GAP  = 2'd2
    } sci_state_t;

    localparam int OFS_STS_LO = 'h00;
    localparam int OFS_STS_HI = 'h01;
    localparam int OFS_EN_LO  = 'h02;
    localparam int OFS_EN_HI  = 'h03;
    localparam int OFS_INS    = 'h08;
    localparam int OFS_REM    = 'h0C;
    localparam int OFS_EJECT  = 'h10;
endpackage

// File: rtl/gpe_regs.sv
module gpe_regs #(
    parameter int LANES  = 2,
    parameter int HP_BIT = 1,
    localparam int W     = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] wr_sts,
    input  logic [LANES-1:0] wr_en,
    input  logic [7:0]       wbyte,
    input  logic             hp_event,
    output logic [W-1:0]     sts,
    output logic [W-1:0]     en
);
    logic [W-1:0] sts_lane, en_lane, sts_nxt;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign sts_lane[b*8 +: 8] = wr_sts[b] ? (sts[b*8 +: 8] & ~wbyte) : sts[b*8 +: 8];
        assign en_lane[b*8 +: 8]  = wr_en[b]  ? wbyte : en[b*8 +: 8];
    end

    always_comb begin
        sts_nxt = sts_lane;
        if (hp_event) sts_nxt[HP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= sts_nxt;
            en  <= en_lane;
        end
    end

    p_other_byte_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts == 2'b01 && !hp_event) |=> sts[15:8] == $past(sts[15:8]));
    p_event_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hp_event |=> sts[HP_BIT]);
    p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(en));
endmodule

// File: rtl/slot_bitmaps.sv
module slot_bitmaps #(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ins,
    input  logic              wr_rem,
    input  logic [SLOTS-1:0]  wdata,
    input  logic              hp_event,
    input  logic              hp_insert,
    input  logic [SLOT_W-1:0] hp_slot,
    output logic [SLOTS-1:0]  ins,
    output logic [SLOTS-1:0]  rem
);
    logic [SLOTS-1:0] slot_bit;
    assign slot_bit = SLOTS'(1) << hp_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins <= '0;
            rem <= '0;
        end else if (hp_event) begin
            ins <= hp_insert  ? slot_bit : '0;
            rem <= !hp_insert ? slot_bit : '0;
        end else begin
            if (wr_ins) ins <= wdata;
            if (wr_rem) rem <= wdata;
        end
    end

    p_event_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hp_event |=> $countones({ins, rem}) == 1);
    p_event_beats_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_event && (wr_ins || wr_rem)) |=> $onehot0(ins) && $onehot0(rem));
endmodule

// File: rtl/eject_encoder.sv
module eject_encoder #(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SLOTS-1:0]  wdata,
    output logic              ej_valid,
    output logic [SLOT_W-1:0] ej_slot
);
    logic [SLOT_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (wdata[i]) low_idx = SLOT_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ej_valid <= 1'b0;
            ej_slot  <= '0;
        end else begin
            ej_valid <= wr && (wdata != '0);
            if (wr && (wdata != '0)) ej_slot <= low_idx;
        end
    end

    p_zero_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata == '0) |=> !ej_valid);
    p_strobe_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> $past(wr));
endmodule

// File: rtl/sci_pulser.sv
module sci_pulser
    import gpe_hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic sci
);
    sci_state_t state, state_nxt;
    logic       pend, pend_nxt;

    always_comb begin
        state_nxt = state;
        pend_nxt  = pend;
        unique case (state)
            SCI_IDLE: if (trig) state_nxt = SCI_HIGH;
            SCI_HIGH: begin
                state_nxt = SCI_GAP;
                if (trig) pend_nxt = 1'b1;
            end
            SCI_GAP: begin
                state_nxt = (pend || trig) ? SCI_HIGH : SCI_IDLE;
                pend_nxt  = 1'b0;
            end
            default: state_nxt = SCI_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCI_IDLE;
            pend  <= 1'b0;
        end else begin
            state <= state_nxt;
            pend  <= pend_nxt;
        end
    end

    always_comb begin
        sci = (state == SCI_HIGH);
    end

    p_sci_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sci |=> !sci);
    p_trig_idle_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && state == SCI_IDLE) |=> sci);
    p_pending_refires_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && sci) |=> !sci ##1 sci);
endmodule

// File: rtl/gpe_hotplug_ctrl.sv
module gpe_hotplug_ctrl
    import gpe_hp_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int ADDR_W = 5,
    parameter int HP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SLOTS-1:0]  bus_wdata,
    output logic [SLOTS-1:0]  bus_rdata,
    input  logic              hp_event,
    input  logic              hp_insert,
    input  logic [SLOT_W-1:0] hp_slot,
    output logic              ej_valid,
    output logic [SLOT_W-1:0] ej_slot,
    output logic              sci
);
    localparam int LANES = 2;

    logic [LANES*8-1:0] sts, en;
    logic [SLOTS-1:0]   ins, rem;
    logic [LANES-1:0]   wr_sts, wr_en;
    logic               wr_ins, wr_rem, wr_ej;

    assign wr_sts = {bus_wr && bus_addr == ADDR_W'(OFS_STS_HI),
                     bus_wr && bus_addr == ADDR_W'(OFS_STS_LO)};
    assign wr_en  = {bus_wr && bus_addr == ADDR_W'(OFS_EN_HI),
                     bus_wr && bus_addr == ADDR_W'(OFS_EN_LO)};
    assign wr_ins = bus_wr && bus_addr == ADDR_W'(OFS_INS);
    assign wr_rem = bus_wr && bus_addr == ADDR_W'(OFS_REM);
    assign wr_ej  = bus_wr && bus_addr == ADDR_W'(OFS_EJECT);

    gpe_regs #(.LANES(LANES), .HP_BIT(HP_BIT)) u_gpe (
        .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wr_en(wr_en),
        .wbyte(bus_wdata[7:0]), .hp_event(hp_event), .sts(sts), .en(en)
    );

    slot_bitmaps #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_ins(wr_ins), .wr_rem(wr_rem),
        .wdata(bus_wdata), .hp_event(hp_event), .hp_insert(hp_insert),
        .hp_slot(hp_slot), .ins(ins), .rem(rem)
    );

    eject_encoder #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ej (
        .clk(clk), .rst_n(rst_n), .wr(wr_ej), .wdata(bus_wdata),
        .ej_valid(ej_valid), .ej_slot(ej_slot)
    );

    sci_pulser u_sci (
        .clk(clk), .rst_n(rst_n), .trig(hp_event && en[HP_BIT]), .sci(sci)
    );

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFS_STS_LO)) bus_rdata = SLOTS'(sts[7:0]);
        else if (bus_addr == ADDR_W'(OFS_STS_HI)) bus_rdata = SLOTS'(sts[15:8]);
        else if (bus_addr == ADDR_W'(OFS_EN_LO))  bus_rdata = SLOTS'(en[7:0]);
        else if (bus_addr == ADDR_W'(OFS_EN_HI))  bus_rdata = SLOTS'(en[15:8]);
        else if (bus_addr == ADDR_W'(OFS_INS))    bus_rdata = ins;
        else if (bus_addr == ADDR_W'(OFS_REM))    bus_rdata = rem;
    end

    p_no_sci_when_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sci && !en[HP_BIT] && !$past(en[HP_BIT]) && !$past(sci)) |=> !sci);
endmodule

// File: tb/sim_gpe_hotplug_ctrl.sv
module sim_gpe_hotplug_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hp_event = 1'b0;
    logic        hp_insert = 1'b0;
    logic [4:0]  hp_slot = '0;
    logic        ej_valid;
    logic [4:0]  ej_slot;
    logic        sci;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    gpe_hotplug_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_event(hp_event),
        .hp_insert(hp_insert), .hp_slot(hp_slot), .ej_valid(ej_valid),
        .ej_slot(ej_slot), .sci(sci)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic hp(input logic ins, input logic [4:0] s);
        hp_event = 1'b1; hp_insert = ins; hp_slot = s;
        @(negedge clk);
        hp_event = 1'b0;
    endtask

    task automatic t_reset;
        rd("R1 sts lo", 5'h00, 0);
        rd("R1 sts hi", 5'h01, 0);
        rd("R1 en lo", 5'h02, 0);
        rd("R1 en hi", 5'h03, 0);
        rd("R1 ins", 5'h08, 0);
        rd("R1 rem", 5'h0C, 0);
        chk("R1 sci", sci, 0);
        chk("R1 ej_valid", ej_valid, 0);
    endtask

    task automatic t_enable_bytes;
        wr(5'h02, 32'hFFFF_FFA5);
        rd("R3 en lo", 5'h02, 32'h0000_00A5);
        rd("R3 en hi kept", 5'h03, 0);
        wr(5'h03, 32'h0000_003C);
        rd("R3 en hi", 5'h03, 32'h3C);
        rd("R3 en lo kept", 5'h02, 32'hA5);
        rd("R1 unmapped", 5'h05, 0);
    endtask

    task automatic t_bitmaps;
        wr(5'h08, 32'hDEAD_BEEF);
        wr(5'h0C, 32'h1234_5678);
        rd("R4 ins", 5'h08, 32'hDEAD_BEEF);
        rd("R4 rem", 5'h0C, 32'h1234_5678);
    endtask

    task automatic t_events_masked;
        // enable bit 1 clear (en lo = 0xA5 has bit1=0)
        hp(1'b1, 5'd7);
        chk("R7 masked no sci", sci, 0);
        rd("R5 ins slot7", 5'h08, 32'h0000_0080);
        rd("R5 rem cleared", 5'h0C, 0);
        rd("R6 sts bit1", 5'h00, 32'h02);
        hp(1'b0, 5'd31);
        rd("R5 rem slot31", 5'h0C, 32'h8000_0000);
        rd("R5 ins cleared", 5'h08, 0);
        @(negedge clk);
        chk("R7 masked still low", sci, 0);
    endtask

    task automatic t_status_w1c;
        hp(1'b1, 5'd0);
        wr(5'h00, 32'h0000_0000);
        rd("R2 zero write keeps", 5'h00, 32'h02);
        wr(5'h01, 32'h0000_00FF);
        rd("R2 hi write keeps lo", 5'h00, 32'h02);
        wr(5'h00, 32'h0000_0002);
        rd("R2 cleared", 5'h00, 0);
    endtask

    task automatic t_sci_pulse;
        wr(5'h02, 32'h02);
        hp(1'b1, 5'd3);
        chk("R7 sci high", sci, 1);
        @(negedge clk);
        chk("R7 sci low after", sci, 0);
        @(negedge clk);
        chk("R7 sci stays low", sci, 0);
    endtask

    task automatic t_sci_back_to_back;
        hp(1'b1, 5'd4);
        chk("R11 first high", sci, 1);
        hp(1'b0, 5'd5);
        chk("R11 gap low", sci, 0);
        @(negedge clk);
        chk("R11 second high", sci, 1);
        @(negedge clk);
        chk("R11 back low", sci, 0);
        rd("R5 last event rem", 5'h0C, 32'h0000_0020);
    endtask

    task automatic t_collision;
        bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'hFFFF_FFFF;
        hp_event = 1'b1; hp_insert = 1'b1; hp_slot = 5'd9;
        @(negedge clk);
        bus_wr = 1'b0; hp_event = 1'b0;
        rd("R10 ins event wins", 5'h08, 32'h0000_0200);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h0000_00FF;
        hp_event = 1'b1; hp_insert = 1'b0; hp_slot = 5'd2;
        @(negedge clk);
        bus_wr = 1'b0; hp_event = 1'b0;
        rd("R10 status bit1 wins", 5'h00, 32'h02);
        rd("R10 rem event", 5'h0C, 32'h0000_0004);
        @(negedge clk);
    endtask

    task automatic t_eject;
        wr(5'h10, 32'h0000_0A00);
        chk("R8 strobe", ej_valid, 1);
        chk("R8 slot", ej_slot, 9);
        @(negedge clk);
        chk("R8 one cycle", ej_valid, 0);
        wr(5'h10, 32'h8000_0000);
        chk("R8 slot31", ej_slot, 31);
        wr(5'h10, 32'h0000_0000);
        chk("R9 zero no strobe", ej_valid, 0);
        rd("R8 eject reads zero", 5'h10, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable_bytes;
        t_bitmaps;
        t_events_masked;
        t_status_w1c;
        t_sci_pulse;
        t_sci_back_to_back;
        t_collision;
        t_eject;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule